// File: doc/BRIEF.md
# Hill-Climbing Regulator with Soft-Start

This block closes the regulation loop of a phase-shifted full-bridge converter. It holds a phase-delay command for the second bridge leg. A longer delay shortens the overlap between the legs and lowers the output, so the delay moves against the output. On every strobed feedback sample it compares the feedback with an internal reference. It then lowers the delay by a programmable step when the feedback is short of the reference, raises it when the feedback is above, and holds it on a match. Constant-voltage or constant-current regulation is chosen by picking either the output-voltage sample or the shunt-voltage sample as feedback.

The reference does not jump to the target. A soft-start ramp raises it linearly from zero after reset, using a remainder accumulator. As long as the target does not exceed the programmed rise time in clock cycles, the ramp lands exactly on the target after that many cycles. After the ramp completes, the reference simply follows the target input. The delay command is clamped between zero and the smaller of a programmable maximum and half the PWM period count. After reset the delay sits at that ceiling, which is the minimum-output state.

Top module: `hc_regulator`

## Requirements
- R1: While reset is held, `delay_o` equals HALF_PERIOD (half of PERIOD_CNT, 1667 by default) and `ref_o` is 0.
- R2: With the target held constant and not above `rise_cycles_i` (T), `ref_o` after the k-th clock edge following reset release equals floor(target*k/T) for k <= T.
- R3: At edge T the ramp reaches the target exactly and holds it. Once the ramp is complete, `ref_o` takes the value of `target_i` one edge after that value is applied.
- R4: With `rise_cycles_i` = 0, `ref_o` equals the target after the first edge following reset release.
- R5: With the target above `rise_cycles_i` (nonzero), `ref_o` rises by one per edge until it equals the target.
- R6: On an edge with `smp_vld_i` = 1, the delay falls by `step_i` when feedback < `ref_o`, rises by `step_i` when feedback > `ref_o`, and is unchanged when they are equal.
- R7: `cc_mode_i` = 0 selects `vout_smp_i` as feedback and `cc_mode_i` = 1 selects `shunt_smp_i`; the unselected sample has no effect on `delay_o`.
- R8: On an edge with `smp_vld_i` = 0, `delay_o` is unchanged unless it exceeds the current limit.
- R9: A decrease larger than the present delay leaves `delay_o` at 0.
- R10: `delay_o` never exceeds min(`delay_max_i`, HALF_PERIOD). An increase past this limit stops at the limit, and lowering `delay_max_i` below the delay pulls `delay_o` down to the new limit on the next edge.
- R11: A `step_i` of 0 leaves `delay_o` unchanged even on a strobe with unequal feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vout_smp_i | input | DW | Output-voltage sample |
| shunt_smp_i | input | DW | Shunt-voltage sample, proportional to load current |
| smp_vld_i | input | 1 | Sample strobe; a loop update happens only on this |
| cc_mode_i | input | 1 | 0 = constant voltage, 1 = constant current |
| target_i | input | DW | Setpoint in scaled integer units |
| rise_cycles_i | input | RISE_W | Soft-start duration in clock cycles |
| step_i | input | STEP_W | Climbing step magnitude |
| delay_max_i | input | DLY_W | Programmable delay ceiling |
| ref_o | output | DW | Present ramped reference |
| delay_o | output | DLY_W | Phase-delay command to the PWM generator |

## Verification
The bench checks the ramp value on each edge against the floor of target times elapsed over rise time. A ramp that rounded, was off by one edge, or overshot would miss the exact landing at cycle T. It tests the degenerate rise times of zero and shorter-than-target. A design that divided by zero or let its remainder grow would jam or wrap the reference in these cases. It drives unequal voltage and shunt samples so that the wrong mode selection moves the delay in the opposite direction. It also walks the delay into both ends of its range, where unsigned wrap-around at zero or a missing clamp at the ceiling would show as a large jump. Finally, it lowers the ceiling under a resting delay to confirm that the delay is pulled down without any strobe.

// File: rtl/hc_regulator.sv
module hc_regulator #(
  parameter int DW         = 12,
  parameter int DLY_W      = 12,
  parameter int RISE_W     = 32,
  parameter int STEP_W     = 4,
  parameter int PERIOD_CNT = 3334
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     vout_smp_i,
  input  logic [DW-1:0]     shunt_smp_i,
  input  logic              smp_vld_i,
  input  logic              cc_mode_i,
  input  logic [DW-1:0]     target_i,
  input  logic [RISE_W-1:0] rise_cycles_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [DLY_W-1:0]  delay_max_i,
  output logic [DW-1:0]     ref_o,
  output logic [DLY_W-1:0]  delay_o
);
  localparam int HALF = PERIOD_CNT / 2;
  localparam logic [DLY_W-1:0] HALF_D = DLY_W'(HALF);

  logic [RISE_W-1:0] acc_q;
  logic              ramp_done_q;
  logic [DW-1:0]     ref_q;
  logic [DLY_W-1:0]  delay_q, delay_nxt;

  wire [RISE_W:0]   acc_sum = {1'b0, acc_q} + (RISE_W+1)'(target_i);
  wire              big_tgt = (RISE_W+1)'(target_i) >= {1'b0, rise_cycles_i};
  wire [DW-1:0]     fb      = cc_mode_i ? shunt_smp_i : vout_smp_i;
  wire [DLY_W-1:0]  lim     = (delay_max_i < HALF_D) ? delay_max_i : HALF_D;
  wire [DLY_W-1:0]  step_d  = DLY_W'(step_i);
  wire [DLY_W:0]    up_sum  = {1'b0, delay_q} + {1'b0, step_d};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q       <= '0;
      ref_q       <= '0;
      ramp_done_q <= 1'b0;
    end else if (ramp_done_q) begin
      ref_q <= target_i;
    end else if (rise_cycles_i == '0 || ref_q >= target_i) begin
      ref_q       <= target_i;
      ramp_done_q <= 1'b1;
    end else if (big_tgt) begin
      ref_q <= ref_q + 1'b1;
    end else if (acc_sum >= {1'b0, rise_cycles_i}) begin
      acc_q <= RISE_W'(acc_sum - {1'b0, rise_cycles_i});
      ref_q <= ref_q + 1'b1;
    end else begin
      acc_q <= RISE_W'(acc_sum);
    end
  end

  always_comb begin
    delay_nxt = delay_q;
    if (smp_vld_i && step_i != '0) begin
      if (fb < ref_q)
        delay_nxt = (delay_q < step_d) ? '0 : delay_q - step_d;
      else if (fb > ref_q)
        delay_nxt = (up_sum > {1'b0, lim}) ? lim : up_sum[DLY_W-1:0];
    end
    if (delay_nxt > lim) delay_nxt = lim;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) delay_q <= HALF_D;
    else        delay_q <= delay_nxt;
  end

  assign ref_o   = ref_q;
  assign delay_o = delay_q;
endmodule

// File: rtl/hc_regulator_chk.sv
module hc_regulator_chk #(
  parameter int DW         = 12,
  parameter int DLY_W      = 12,
  parameter int STEP_W     = 4,
  parameter int PERIOD_CNT = 3334
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DW-1:0]     vout_smp_i,
  input logic [DW-1:0]     shunt_smp_i,
  input logic              smp_vld_i,
  input logic              cc_mode_i,
  input logic [STEP_W-1:0] step_i,
  input logic [DLY_W-1:0]  delay_max_i,
  input logic [DW-1:0]     ref_o,
  input logic [DLY_W-1:0]  delay_o
);
  localparam logic [DLY_W-1:0] CEIL = DLY_W'(PERIOD_CNT / 2);
  wire [DLY_W-1:0] ck_lim = (delay_max_i < CEIL) ? delay_max_i : CEIL;
  wire [DW-1:0]    ck_fb  = cc_mode_i ? shunt_smp_i : vout_smp_i;
  wire             in_lim = delay_o <= ck_lim;

  p_ceiling_r10: assert property (@(posedge clk) disable iff (!rst_n)
    delay_o <= CEIL);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld_i && in_lim) |=> delay_o == $past(delay_o));

  p_step_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && in_lim && ck_fb < ref_o && delay_o >= DLY_W'(step_i))
      |=> delay_o == $past(delay_o) - DLY_W'($past(step_i)));

  p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && in_lim && ck_fb < ref_o && delay_o < DLY_W'(step_i))
      |=> delay_o == '0);

  p_match_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && in_lim && ck_fb == ref_o) |=> $stable(delay_o));

  p_zero_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i == '0 && in_lim) |=> $stable(delay_o));
endmodule

bind hc_regulator hc_regulator_chk #(
  .DW(DW), .DLY_W(DLY_W), .STEP_W(STEP_W), .PERIOD_CNT(PERIOD_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vout_smp_i(vout_smp_i), .shunt_smp_i(shunt_smp_i),
  .smp_vld_i(smp_vld_i), .cc_mode_i(cc_mode_i), .step_i(step_i),
  .delay_max_i(delay_max_i), .ref_o(ref_o), .delay_o(delay_o)
);

// File: tb/hc_regulator_test.sv
module hc_regulator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] vout_smp_i = '0, shunt_smp_i = '0, target_i = '0;
  logic [11:0] delay_max_i = 12'd1667;
  logic [31:0] rise_cycles_i = '0;
  logic [3:0]  step_i = '0;
  logic        smp_vld_i = 1'b0, cc_mode_i = 1'b0;
  logic [11:0] ref_o, delay_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hc_regulator uut (
    .clk(clk), .rst_n(rst_n), .vout_smp_i(vout_smp_i), .shunt_smp_i(shunt_smp_i),
    .smp_vld_i(smp_vld_i), .cc_mode_i(cc_mode_i), .target_i(target_i),
    .rise_cycles_i(rise_cycles_i), .step_i(step_i), .delay_max_i(delay_max_i),
    .ref_o(ref_o), .delay_o(delay_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {mode, vout, shunt, vld, step, dmax, expected delay}; reference held at 200
  localparam logic [53:0] VEC [12] = '{
    {1'b0, 12'd100, 12'd300, 1'b1, 4'd1,  12'd1667, 12'd1666}, // R6 below -> down
    {1'b0, 12'd100, 12'd300, 1'b1, 4'd5,  12'd1667, 12'd1661}, // R6 larger step
    {1'b0, 12'd250, 12'd0,   1'b1, 4'd3,  12'd1667, 12'd1664}, // R6 above -> up
    {1'b0, 12'd200, 12'd0,   1'b1, 4'd3,  12'd1667, 12'd1664}, // R6 equal hold
    {1'b1, 12'd100, 12'd250, 1'b1, 4'd2,  12'd1667, 12'd1666}, // R7 shunt above
    {1'b1, 12'd300, 12'd150, 1'b1, 4'd4,  12'd1667, 12'd1662}, // R7 shunt below
    {1'b0, 12'd0,   12'd0,   1'b0, 4'd4,  12'd1667, 12'd1662}, // R8 no strobe
    {1'b0, 12'd300, 12'd0,   1'b1, 4'd8,  12'd1667, 12'd1667}, // R10 stop at ceiling
    {1'b0, 12'd0,   12'd0,   1'b1, 4'd0,  12'd1667, 12'd1667}, // R11 zero step
    {1'b0, 12'd0,   12'd0,   1'b0, 4'd0,  12'd1000, 12'd1000}, // R10 lowered max
    {1'b0, 12'd0,   12'd0,   1'b0, 4'd0,  12'd3000, 12'd1000}, // R8 raised max, idle
    {1'b0, 12'd300, 12'd0,   1'b1, 4'd15, 12'd3000, 12'd1015}  // R6 up under half-period cap
  };

  initial begin
    int model;
    // R1 reset state
    target_i = 12'd4; rise_cycles_i = 32'd10; step_i = 4'd1;
    repeat (3) @(negedge clk);
    check("R1 delay", delay_o, 1667);
    check("R1 ref", ref_o, 0);
    rst_n = 1'b1;
    for (int k = 1; k <= 13; k++) begin
      tick();
      if (k <= 10) check("R2 ramp", ref_o, (4 * k) / 10);
      else         check("R3 hold", ref_o, 4);
      check("R8 idle delay", delay_o, 1667);
    end
    check("R3 exact landing", ref_o, 4);
    target_i = 12'd200;
    tick();
    check("R3 follow target", ref_o, 200);

    for (int i = 0; i < 12; i++) begin
      cc_mode_i   = VEC[i][53];
      vout_smp_i  = VEC[i][52:41];
      shunt_smp_i = VEC[i][40:29];
      smp_vld_i   = VEC[i][28];
      step_i      = VEC[i][27:24];
      delay_max_i = VEC[i][23:12];
      tick();
      check($sformatf("R6/R7/R8/R10/R11 vector %0d", i), delay_o, int'(VEC[i][11:0]));
    end

    // R9 drive to floor
    model = 1015;
    cc_mode_i = 1'b0; vout_smp_i = 12'd0; step_i = 4'd15; smp_vld_i = 1'b1;
    for (int i = 0; i < 70; i++) begin
      tick();
      model = (model < 15) ? 0 : model - 15;
      check("R9 floor", delay_o, model);
    end
    // R10 climb into half-period cap
    vout_smp_i = 12'd4095;
    for (int i = 0; i < 120; i++) begin
      tick();
      model = (model + 15 > 1667) ? 1667 : model + 15;
      check("R10 cap", delay_o, model);
    end
    smp_vld_i = 1'b0;

    // R4 zero rise time
    rst_n = 1'b0; target_i = 12'd50; rise_cycles_i = 32'd0;
    tick();
    check("R1 reset again", ref_o, 0);
    rst_n = 1'b1;
    tick();
    check("R4 immediate", ref_o, 50);

    // R5 target above rise time
    rst_n = 1'b0; target_i = 12'd9; rise_cycles_i = 32'd3;
    tick();
    rst_n = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      tick();
      check("R5 unit ramp", ref_o, (k < 9) ? k : 9);
    end

    // R2 longer ramp, non-integer slope
    rst_n = 1'b0; target_i = 12'd7; rise_cycles_i = 32'd23;
    tick();
    rst_n = 1'b1;
    for (int k = 1; k <= 25; k++) begin
      tick();
      check("R2 ramp 7/23", ref_o, (k <= 23) ? (7 * k) / 23 : 7);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule